// File: doc/BRIEF.md
# Serial-in latched parallel-out register

This block turns a serial bit stream into a parallel word held on a set of outputs. Bits enter one at a time on a serial data pin. A chain of shift stages moves them along on every rising edge of a dedicated shift clock. A second, independent storage clock copies the whole chain into a holding register in one step. The parallel outputs therefore change only when the storage clock rises, however much shifting happens before that edge.

The last shift stage also drives a serial cascade output. That output can feed the serial input of another copy of the block, so that wider words can be built by chaining. An active-low clear empties the shift chain at once, with no clock needed. The clear leaves the holding register alone. An active-low output enable either presents the held word on the parallel pins or floats all of them to high impedance. A companion valid flag reports which of the two states the pins are in.

Top module: `sipo_latch_top`

## Requirements
- R1: On each rising edge of shift_clk, ser_in is loaded into stage 0 and every stage k (1 to 7) takes the previous value of stage k-1.
- R2: On each rising edge of store_clk, all 8 stages are copied into the holding register at once, and par_out bit k shows stage k. Between storage edges, par_out does not change, even while shifting goes on.
- R3: When shift_clk and store_clk rise on the same edge, the holding register takes the contents the stages had before that edge's shift.
- R4: ser_out always equals stage 7, whatever the value of out_en_n.
- R5: Driving clear_n low sets all 8 stages to 0 at once, without any clock edge.
- R6: clear_n has no effect on the holding register, so par_out keeps its value through a clear until the next store_clk edge.
- R7: While clear_n is low, rising edges of shift_clk are ignored and the stages stay at 0.
- R8: While out_en_n is 0, par_out shows the holding register and par_valid is 1. While out_en_n is 1, every bit of par_out is high impedance and par_valid is 0.
- R9: When a byte is shifted in most significant bit first over 8 shift edges, a storage edge presents it unchanged on par_out, so the first bit shifted in appears on par_out[7].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shift_clk | input | 1 | Shift clock, rising edge active |
| store_clk | input | 1 | Storage clock, rising edge active |
| clear_n | input | 1 | Asynchronous clear of the shift stages, active low |
| out_en_n | input | 1 | Parallel output enable, active low |
| ser_in | input | 1 | Serial data input |
| par_out | output | 8 | Holding register contents, or high impedance |
| par_valid | output | 1 | 1 while par_out is driven |
| ser_out | output | 1 | Serial cascade output from stage 7 |

## Verification
A shift and a storage capture can land on the same instant when both clocks are tied together. The bench provokes this by raising both clocks in one pulse. It then judges the parallel word against the contents the chain held before that pulse, and afterwards confirms that the chain did shift, by making a separate storage pulse. A second collision comes from raising the shift clock while the clear is held. The bench then checks that the cascade output stays at zero and that a later capture reads all zeros.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
  localparam int unsigned STAGES = 8;
  typedef logic [STAGES-1:0] word_t;
endpackage

// File: rtl/sipo_shift_chain.sv
module sipo_shift_chain #(
  parameter int unsigned W = 8
) (
  input  logic         shift_clk,
  input  logic         clear_n,
  input  logic         ser_in,
  output logic [W-1:0] stage_q
);
  localparam int unsigned LAST = W - 1;

  always_ff @(posedge shift_clk or negedge clear_n) begin
    if (!clear_n) stage_q[0] <= 1'b0;
    else          stage_q[0] <= ser_in;
  end

  for (genvar k = 1; k <= LAST; k++) begin : g_stage
    always_ff @(posedge shift_clk or negedge clear_n) begin
      if (!clear_n) stage_q[k] <= 1'b0;
      else          stage_q[k] <= stage_q[k-1];
    end
  end

  // R1
  head_load_chk: assert property (@(posedge shift_clk) disable iff (!clear_n)
    1'b1 |=> stage_q[0] == $past(ser_in));

  // R1
  chain_move_chk: assert property (@(posedge shift_clk) disable iff (!clear_n)
    1'b1 |=> stage_q[LAST:1] == $past(stage_q[LAST-1:0]));
endmodule

// File: rtl/sipo_hold_reg.sv
module sipo_hold_reg #(
  parameter int unsigned W = 8
) (
  input  logic         store_clk,
  input  logic         clear_n,
  input  logic [W-1:0] stage_q,
  output logic [W-1:0] hold_q
);
  always_ff @(posedge store_clk) begin
    hold_q <= stage_q;
  end

  // R2
  capture_chk: assert property (@(posedge store_clk) disable iff (!clear_n)
    1'b1 |=> hold_q == $past(stage_q));
endmodule

// File: rtl/sipo_out_drv.sv
module sipo_out_drv #(
  parameter int unsigned W = 8
) (
  input  logic         out_en_n,
  input  logic [W-1:0] hold_q,
  output logic [W-1:0] par_out,
  output logic         par_valid
);
  logic drive;
  assign drive     = ~out_en_n;
  assign par_valid = drive;
  assign par_out   = drive ? hold_q : {W{1'bz}};
endmodule

// File: rtl/sipo_latch_top.sv
module sipo_latch_top
  import sipo_pkg::*;
(
  input  logic        shift_clk,
  input  logic        store_clk,
  input  logic        clear_n,
  input  logic        out_en_n,
  input  logic        ser_in,
  output logic [STAGES-1:0] par_out,
  output logic        par_valid,
  output logic        ser_out
);
  word_t stage_q;
  word_t hold_q;

  sipo_shift_chain #(.W(STAGES)) chain_i (
    .shift_clk(shift_clk), .clear_n(clear_n), .ser_in(ser_in), .stage_q(stage_q)
  );

  sipo_hold_reg #(.W(STAGES)) hold_i (
    .store_clk(store_clk), .clear_n(clear_n), .stage_q(stage_q), .hold_q(hold_q)
  );

  sipo_out_drv #(.W(STAGES)) drv_i (
    .out_en_n(out_en_n), .hold_q(hold_q), .par_out(par_out), .par_valid(par_valid)
  );

  assign ser_out = stage_q[STAGES-1];

  // R4
  cascade_tap_chk: assert property (@(posedge shift_clk) disable iff (!clear_n)
    1'b1 |=> ser_out == $past(stage_q[STAGES-2]));
endmodule

// File: tb/sipo_latch_top_tb_top.sv
`timescale 1ns/1ps
module sipo_latch_top_tb_top;
  logic clk = 1'b0;
  logic shift_clk = 1'b0, store_clk = 1'b0;
  logic clear_n = 1'b0, out_en_n = 1'b0, ser_in = 1'b0;
  logic [7:0] par_out;
  logic par_valid, ser_out;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sipo_latch_top dut_i (
    .shift_clk(shift_clk), .store_clk(store_clk), .clear_n(clear_n),
    .out_en_n(out_en_n), .ser_in(ser_in), .par_out(par_out),
    .par_valid(par_valid), .ser_out(ser_out)
  );

  task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic chk1(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic pulse(input bit sh, input bit st, input logic d);
    ser_in = d;
    #1;
    if (sh) shift_clk = 1'b1;
    if (st) store_clk = 1'b1;
    #2;
    shift_clk = 1'b0;
    store_clk = 1'b0;
    #1;
  endtask

  task automatic shift_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) pulse(1'b1, 1'b0, b[i]);
  endtask

  task automatic t_reset();
    clear_n = 1'b0; out_en_n = 1'b0;
    #3;
    pulse(1'b0, 1'b1, 1'b0);
    chk8("R5 reset capture", par_out, 8'h00);
    chk1("R5 reset ser_out", ser_out, 1'b0);
    chk1("R8 valid when enabled", par_valid, 1'b1);
    clear_n = 1'b1;
    #2;
  endtask

  task automatic t_load();
    shift_byte(8'hA5);
    chk8("R2 no change before store", par_out, 8'h00);
    pulse(1'b0, 1'b1, 1'b0);
    chk8("R9 byte presented", par_out, 8'hA5);
    chk1("R9 first bit at par_out[7]", par_out[7], 1'b1);
  endtask

  task automatic t_cascade();
    logic [7:0] old = 8'hA5, nxt = 8'h3C;
    out_en_n = 1'b1;
    #1;
    chk8("R8 high impedance", par_out, 8'hzz);
    chk1("R8 valid low", par_valid, 1'b0);
    for (int i = 7; i >= 0; i--) begin
      pulse(1'b1, 1'b0, nxt[i]);
      chk1("R4 cascade tracks stage 7", ser_out, (i == 0) ? nxt[7] : old[i-1]);
    end
    out_en_n = 1'b0;
    #1;
    chk8("R2 held during shifting", par_out, 8'hA5);
    chk1("R1 stage 7 after full shift", ser_out, 1'b0);
  endtask

  task automatic t_tied();
    pulse(1'b1, 1'b1, 1'b1);
    chk8("R3 tied clocks capture pre-shift", par_out, 8'h3C);
    pulse(1'b0, 1'b1, 1'b0);
    chk8("R1 shifted contents", par_out, 8'h79);
  endtask

  task automatic t_clear();
    shift_byte(8'hFF);
    pulse(1'b0, 1'b1, 1'b0);
    chk8("R2 all ones", par_out, 8'hFF);
    chk1("R4 ser_out one", ser_out, 1'b1);
    clear_n = 1'b0;
    #1;
    chk1("R5 async clear without clock", ser_out, 1'b0);
    chk8("R6 storage untouched by clear", par_out, 8'hFF);
    for (int i = 0; i < 8; i++) pulse(1'b1, 1'b0, 1'b1);
    chk1("R7 shift ignored during clear", ser_out, 1'b0);
    chk8("R6 outputs hold through clear", par_out, 8'hFF);
    clear_n = 1'b1;
    #2;
    pulse(1'b0, 1'b1, 1'b0);
    chk8("R7 stages stayed zero", par_out, 8'h00);
  endtask

  initial begin
    t_reset();
    t_load();
    t_cascade();
    t_tied();
    t_clear();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule